// File: doc/BRIEF.md
# Eight-Core Hub Time-Slot Arbiter with Twin Pairing

The arbiter gives eight processor cores turns at a single shared memory hub. A slot counter steps through the cores one clock at a time, so each core owns exactly one cycle in every rotation of eight. Each cycle the arbiter raises at most one grant line, and it reports which core owns the current slot.

Each core has a 2-bit mode that decides two things: who may use the core's own slot, and whether the core may pick up slots that their owners leave idle. Cores are tied into fixed twin pairs, core i with core i+4. One twin can donate its slot, and the other twin can claim it ahead of everyone else. A core in the default mode uses only its own slot and never receives spare cycles, so its timing cannot come to depend on how busy the other cores are. A mode written in the middle of a rotation is held back until slot 0 of the next rotation.

Requests and modes are plain level inputs. The grant is a combinational function of the present request vector, the current slot and the latched modes, so a core sees its grant in the same cycle that it asserts its request.

Top module: `hub_slot_arbiter`

## Requirements
- R1: After reset `slot_owner` is 0. It advances by one every clock and wraps from 7 back to 0.
- R2: At most one bit of `grant` is high in any cycle, and a core is granted only while its `req` bit is high. If no eligible core requests, the cycle has no grant.
- R3: Core i's mode sits at `mode[2i+1:2i]` and is encoded as 00 plain, 01 giving, 10 greedy, 11 low-bandwidth. After reset every core behaves as mode 00 until a new mode is loaded. A requesting mode-00 owner is granted its own slot.
- R4: A core whose active mode is 00 is never granted a slot that belongs to another core.
- R5: Twins are cores i and i+4 (0/4, 1/5, 2/6, 3/7). In the slot of a mode-01 owner, a twin in mode 10 that is requesting wins first, then the owner, then the spare pool.
- R6: A mode-10 owner has first claim on its own slot. A requesting mode-10 core whose twin is in mode 01 is therefore granted two slots in every rotation.
- R7: A mode-11 owner is granted its own slot only when no other eligible core is requesting in that cycle.
- R8: A slot that the owner-side rules leave unused goes to a requesting core in mode 01, 10 or 11 other than the owner (the spare pool).
- R9: The spare-pool winner is the first requester at or after a rotating pointer, counting upward and wrapping. The pointer is 0 after reset and moves to the winner's index plus one after each spare-pool grant.
- R10: A mode presented on `mode` is loaded at the clock edge that ends slot 7. It governs the whole of the next rotation and never changes mid-rotation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 8 | Per-core hub request, bit i for core i |
| mode | input | 16 | Per-core 2-bit mode, bits 2i+1:2i for core i |
| grant | output | 8 | One-hot (or zero) hub grant for this cycle |
| slot_owner | output | 3 | Index of the core that owns the current slot |

## Verification
The first pattern has every core requesting under the default modes. This separates the plain rotation from any sharing, and it shows that modes driven during the first rotation have no effect until slot 0 comes round again. A lone requester in mode 00 shows that idle slots are not passed to default cores. A giving/greedy pair with both twins requesting shows that the greedy twin takes the donor's slot, while the same pair with the greedy role removed shows the owner keeping its slot. Low-bandwidth cores competing with one another, and with themselves as owner, exercise the owner fallback and the rotation of the spare pointer. Several hundred cycles of pseudo-random requests and mode changes then compare every grant against an independent model.

// File: rtl/hub_arb_pkg.sv
package hub_arb_pkg;
  // per-core hub mode; encoding is decoded by the arbiter priority logic
  typedef enum logic [1:0] {
    HM_PLAIN  = 2'b00,
    HM_GIVE   = 2'b01,
    HM_GREEDY = 2'b10,
    HM_LOW    = 2'b11
  } hub_mode_e;
endpackage

// File: rtl/hub_slot_counter.sv
module hub_slot_counter #(
  parameter int N    = 8,
  parameter int IDXW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [IDXW-1:0] slot_q,
  output logic            last_slot
);
  localparam logic [IDXW-1:0] LAST = IDXW'(N - 1);

  assign last_slot = (slot_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         slot_q <= '0;
    else if (last_slot) slot_q <= '0;
    else                slot_q <= slot_q + 1'b1;
  end
endmodule

// File: rtl/hub_mode_shadow.sv
module hub_mode_shadow #(
  parameter int N = 8,
  localparam int MW = 2 * N
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [MW-1:0] mode_in,
  output logic [MW-1:0] act_q
);
  // modes enter only at a rotation boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    act_q <= '0;
    else if (load) act_q <= mode_in;
  end
endmodule

// File: rtl/hub_spare_picker.sv
module hub_spare_picker #(
  parameter int N    = 8,
  parameter int IDXW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    cand,
  input  logic            advance,
  output logic            found,
  output logic [IDXW-1:0] win_idx
);
  localparam logic [IDXW-1:0] LAST = IDXW'(N - 1);

  logic [IDXW-1:0] ptr_q;

  always_comb begin
    int idx;
    found   = 1'b0;
    win_idx = '0;
    for (int k = 0; k < N; k++) begin
      idx = (int'(ptr_q) + k) % N;
      if (!found && cand[idx]) begin
        found   = 1'b1;
        win_idx = IDXW'(idx);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr_q <= '0;
    else if (advance) ptr_q <= (win_idx == LAST) ? '0 : win_idx + 1'b1;
  end
endmodule

// File: rtl/hub_slot_arbiter.sv
module hub_slot_arbiter
  import hub_arb_pkg::*;
#(
  parameter int N_CORES = 8,
  localparam int IDXW = $clog2(N_CORES),
  localparam int HALF = N_CORES / 2,
  localparam int MW   = 2 * N_CORES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_CORES-1:0] req,
  input  logic [MW-1:0]      mode,
  output logic [N_CORES-1:0] grant,
  output logic [IDXW-1:0]    slot_owner
);
  logic            last_slot;
  logic [MW-1:0]   act_mode_q;
  hub_mode_e       act [N_CORES];
  logic [N_CORES-1:0] pool;
  logic            pool_found;
  logic [IDXW-1:0] pool_win;
  logic            use_pool;
  logic            gv;
  logic [IDXW-1:0] gidx;
  logic [IDXW-1:0] twin;
  hub_mode_e       own_mode;

  function automatic logic [IDXW-1:0] twin_of(input logic [IDXW-1:0] i);
    return IDXW'((int'(i) + HALF) % N_CORES);
  endfunction

  hub_slot_counter #(.N(N_CORES), .IDXW(IDXW)) u_slot (
    .clk(clk), .rst_n(rst_n), .slot_q(slot_owner), .last_slot(last_slot)
  );

  hub_mode_shadow #(.N(N_CORES)) u_modes (
    .clk(clk), .rst_n(rst_n), .load(last_slot), .mode_in(mode), .act_q(act_mode_q)
  );

  for (genvar i = 0; i < N_CORES; i++) begin : g_core
    assign act[i]  = hub_mode_e'(act_mode_q[2*i +: 2]);
    // spare pool: opted-in requesters other than the slot owner
    assign pool[i] = req[i] && (act[i] != HM_PLAIN) && (slot_owner != IDXW'(i));
  end

  hub_spare_picker #(.N(N_CORES), .IDXW(IDXW)) u_pick (
    .clk(clk), .rst_n(rst_n), .cand(pool), .advance(use_pool),
    .found(pool_found), .win_idx(pool_win)
  );

  assign twin     = twin_of(slot_owner);
  assign own_mode = act[slot_owner];

  always_comb begin
    gv       = 1'b0;
    gidx     = slot_owner;
    use_pool = 1'b0;
    unique case (own_mode)
      HM_GIVE: begin
        if (act[twin] == HM_GREEDY && req[twin]) begin
          gv = 1'b1; gidx = twin;
        end else if (req[slot_owner]) begin
          gv = 1'b1;
        end else if (pool_found) begin
          gv = 1'b1; gidx = pool_win; use_pool = 1'b1;
        end
      end
      HM_LOW: begin
        if (pool_found) begin
          gv = 1'b1; gidx = pool_win; use_pool = 1'b1;
        end else if (req[slot_owner]) begin
          gv = 1'b1;
        end
      end
      default: begin
        if (req[slot_owner]) begin
          gv = 1'b1;
        end else if (pool_found) begin
          gv = 1'b1; gidx = pool_win; use_pool = 1'b1;
        end
      end
    endcase
  end

  always_comb begin
    grant = '0;
    if (gv) grant[gidx] = 1'b1;
  end
endmodule

// File: rtl/hub_slot_arbiter_chk.sv
module hub_slot_arbiter_chk #(
  parameter int N    = 8,
  parameter int IDXW = $clog2(N)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [N-1:0]    req,
  input logic [N-1:0]    grant,
  input logic [IDXW-1:0] slot_owner,
  input logic [2*N-1:0]  act_flat
);
  localparam logic [IDXW-1:0] LAST = IDXW'(N - 1);

  logic [IDXW-1:0] twin;
  assign twin = IDXW'((int'(slot_owner) + N / 2) % N);

  // R2
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant));

  // R2
  grant_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n) (grant & ~req) == '0);

  // R1
  slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_owner != LAST) |=> slot_owner == $past(slot_owner) + 1'b1);

  // R1
  slot_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_owner == LAST) |=> slot_owner == '0);

  // R10
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_owner != '0) |-> $stable(act_flat));

  // R5
  greedy_twin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_flat[2*slot_owner +: 2] == 2'b01 && act_flat[2*twin +: 2] == 2'b10 && req[twin])
      |-> grant[twin]);

  for (genvar i = 0; i < N; i++) begin : g_plain
    // R4
    plain_own_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant[i] && act_flat[2*i +: 2] == 2'b00) |-> slot_owner == IDXW'(i));
  end
endmodule

bind hub_slot_arbiter hub_slot_arbiter_chk #(.N(N_CORES), .IDXW(IDXW)) chk_i (
  .clk(clk), .rst_n(rst_n), .req(req), .grant(grant),
  .slot_owner(slot_owner), .act_flat(act_mode_q)
);

// File: tb/hub_slot_arbiter_tb_top.sv
module hub_slot_arbiter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  req = '0;
  logic [15:0] mode = '0;
  logic [7:0]  grant;
  logic [2:0]  slot_owner;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  hub_slot_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .mode(mode),
    .grant(grant), .slot_owner(slot_owner)
  );

  // scoreboard queues
  logic [7:0] q_g [$];
  logic [2:0] q_s [$];
  string      q_t [$];

  // reference model state
  int         m_slot = 0;
  int         m_ptr  = 0;
  logic [1:0] m_act [8];

  task automatic check(input bit ok, input string tag, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  // one cycle: apply inputs, predict result, advance the model
  task automatic drive(input logic [7:0] r, input logic [15:0] m, input string phase);
    int o, t, sp, win, k, idx;
    logic [7:0] eg;
    string rule;
    bit spare;
    req  = r;
    mode = m;
    o = m_slot; t = (o + 4) % 8;
    sp = -1;
    for (k = 0; k < 8; k++) begin
      idx = (m_ptr + k) % 8;
      if (sp < 0 && idx != o && r[idx] && m_act[idx] != 2'b00) sp = idx;
    end
    win = -1; spare = 0; rule = "R8";
    case (m_act[o])
      2'b01: if (m_act[t] == 2'b10 && r[t]) begin win = t; rule = "R5"; end
             else if (r[o]) begin win = o; rule = "R5"; end
             else if (sp >= 0) begin win = sp; spare = 1; rule = "R9"; end
      2'b11: if (sp >= 0) begin win = sp; spare = 1; rule = "R7"; end
             else if (r[o]) begin win = o; rule = "R7"; end
      2'b10: if (r[o]) begin win = o; rule = "R6"; end
             else if (sp >= 0) begin win = sp; spare = 1; rule = "R9"; end
      default: if (r[o]) begin win = o; rule = "R3"; end
               else if (sp >= 0) begin win = sp; spare = 1; rule = "R4"; end
    endcase
    eg = '0;
    if (win >= 0) eg[win] = 1'b1;
    q_g.push_back(eg);
    q_s.push_back(3'(o));
    q_t.push_back({phase, "/", rule});
    if (spare) m_ptr = (win + 1) % 8;
    if (m_slot == 7) for (k = 0; k < 8; k++) m_act[k] = m[2*k +: 2];
    m_slot = (m_slot + 1) % 8;
    @(negedge clk);
  endtask

  // monitor: compare late in each cycle, away from the rising edge
  initial begin
    forever begin
      @(negedge clk);
      #4;
      if (q_g.size() > 0) begin
        logic [7:0] eg;
        logic [2:0] es;
        string tg;
        eg = q_g.pop_front();
        es = q_s.pop_front();
        tg = q_t.pop_front();
        check(grant === eg && slot_owner === es, tg,
              $sformatf("grant=%b slot=%0d expected grant=%b slot=%0d",
                        grant, slot_owner, eg, es));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    logic [15:0] rmode;
    for (int k = 0; k < 8; k++) m_act[k] = 2'b00;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(slot_owner === 3'd0 && grant === 8'd0, "R1",
          $sformatf("reset slot=%0d grant=%b expected slot=0 grant=0", slot_owner, grant));
    rst_n = 1'b1;

    // R3/R10: all request; greedy modes driven now apply only from rotation 2
    for (int c = 0; c < 16; c++) drive(8'hFF, {8{2'b10}}, "R3_R10_all");
    // R4/R8: lone plain requester gets only its own slot
    for (int c = 0; c < 24; c++) drive(8'h08, 16'h0000, "R4_lone");
    // R5/R6: core1 greedy, core5 giving, both requesting
    for (int c = 0; c < 32; c++) drive(8'h22, 16'h0400 | 16'h0008, "R6_pair");
    // R5: core5 giving, twin plain -> owner keeps it; idle give slot to low core2
    for (int c = 0; c < 16; c++) drive(8'h22, 16'h0400, "R5_owner");
    for (int c = 0; c < 16; c++) drive(8'h04, 16'h0400 | 16'h0030, "R5_spare");
    // R7: low-bandwidth cores 2 and 6 compete, then core2 alone
    for (int c = 0; c < 24; c++) drive(8'h44, 16'h3030, "R7_pair");
    for (int c = 0; c < 16; c++) drive(8'h04, 16'h3030, "R7_alone");
    // R9: three low cores rotate through the spare pool
    for (int c = 0; c < 32; c++) drive(8'h2A, 16'h0CCC, "R9_rotate");
    // R10: change modes mid-rotation repeatedly
    for (int c = 0; c < 24; c++) drive(8'hFF, (c % 3 == 1) ? 16'h5A5A : 16'hA5A5, "R10_mid");
    // R2: pseudo-random requests and modes
    lfsr  = 16'hACE1;
    rmode = 16'h0000;
    for (int c = 0; c < 400; c++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (c % 11 == 0) rmode = {lfsr[7:0], lfsr[15:8]};
      drive(lfsr[7:0] & lfsr[15:8] ^ lfsr[11:4], rmode, "R2_random");
    end
    drive(8'h00, 16'h0000, "R8_idle");
    req = '0;
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule